// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block turns the 32-bit addresses of memory-mapped bus requests into 64-bit link addresses. The link addresses are then handed to a transaction layer. The remote address space is cut into pages of one size, fixed at build time. A small table holds one 64-bit page base for each page slot. The bits of the request address above the page offset select a slot. That slot's base supplies the high part of the outgoing address, and the page offset is copied unchanged. Each slot also holds a 2-bit attribute, which travels with the translated request.

Software fills the table through a simple write port. The same index input drives a combinational read-back. A request flagged as wide-address skips the table and leaves with its full 64-bit address unchanged. A request whose slot number is beyond the table size is answered with an error flag and no valid output. Every result appears one clock after its request, and a new request can be issued on every cycle.

Top module: `pg_xlate`

## Requirements
- R1: After reset is released, rsp_valid_o, rsp_err_o, rsp_attr_o and rsp_addr_o are all zero, and every table slot reads back a zero base and zero attribute.
- R2: A write with cfg_we_i high and cfg_idx_i below NUM_ENTRIES stores cfg_base_i with its low PAGE_BITS bits forced to zero, together with cfg_attr_i. cfg_rd_base_o and cfg_rd_attr_o show the slot selected by cfg_idx_i.
- R3: A write whose cfg_idx_i is NUM_ENTRIES or above changes no slot. A read-back at such an index returns zero base and zero attribute.
- R4: For a request with req_valid_i high and req_wide_i low, and slot number s = req_addr_i[31:0] >> PAGE_BITS below NUM_ENTRIES, the next cycle shows rsp_valid_o high, rsp_err_o low, rsp_addr_o = {base of slot s bits 63..PAGE_BITS, req_addr_i[PAGE_BITS-1:0]} and rsp_attr_o = attribute of slot s.
- R5: For a non-wide request whose slot number s is NUM_ENTRIES or above, the next cycle shows rsp_err_o high, rsp_valid_o low, and rsp_addr_o and rsp_attr_o zero.
- R6: For a request with req_wide_i high, the next cycle shows rsp_valid_o high, rsp_err_o low, rsp_attr_o zero and rsp_addr_o equal to the full 64-bit req_addr_i, whatever its slot number.
- R7: For a non-wide request, req_addr_i[63:32] has no effect on the response.
- R8: A lookup of a slot in the same cycle as a write to that slot uses the slot's old contents. A lookup in the next cycle uses the new contents.
- R9: Requests are accepted on consecutive cycles, and each gets its own response exactly one cycle later.
- R10: In a cycle after one with req_valid_i low, rsp_valid_o and rsp_err_o are low, and rsp_addr_o and rsp_attr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | IW = clog2(NUM_ENTRIES) | Slot index for both write and read-back |
| cfg_base_i | input | OUT_AW | Page base to write |
| cfg_attr_i | input | 2 | Attribute to write |
| cfg_rd_base_o | output | OUT_AW | Stored base of slot cfg_idx_i (combinational) |
| cfg_rd_attr_o | output | 2 | Stored attribute of slot cfg_idx_i (combinational) |
| req_valid_i | input | 1 | Request present |
| req_wide_i | input | 1 | Wide-address request, bypasses translation |
| req_addr_i | input | OUT_AW | Request address; only bits 31..0 are used when not wide |
| rsp_valid_o | output | 1 | Translated request valid |
| rsp_addr_o | output | OUT_AW | Outgoing address |
| rsp_attr_o | output | 2 | Attribute of the selected slot |
| rsp_err_o | output | 1 | Slot number out of range |

## Verification
A table write can land in the same cycle as a lookup of the same slot. The bench provokes this by driving a write to a slot while a request selects that slot, then a second request to that slot on the very next cycle. The bench's behavioural model applies the write only after it has computed the response for that cycle. It therefore expects the old base and attribute first and the new ones one cycle later, and it compares the response on every clock.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int ATTR_W = 2;
  localparam int BUS_AW = 32;
  typedef logic [ATTR_W-1:0] attr_t;
endpackage

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
#(
  parameter int NUM_ENTRIES = 12,
  parameter int OUT_AW      = 64,
  parameter int PAGE_BITS   = 12,
  parameter int IW          = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IW-1:0]           wr_idx_i,
  input  logic [OUT_AW-1:0]       wr_base_i,
  input  attr_t                   wr_attr_i,
  input  logic [IW-1:0]           lk_idx_i,
  output logic [OUT_AW-1:0]       lk_base_o,
  output attr_t                   lk_attr_o,
  input  logic [IW-1:0]           rd_idx_i,
  output logic [OUT_AW-1:0]       rd_base_o,
  output attr_t                   rd_attr_o
);
  localparam int HW = OUT_AW - PAGE_BITS;

  logic [HW-1:0] hi_q   [NUM_ENTRIES];
  attr_t         attr_q [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q[g]   <= '0;
        attr_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        hi_q[g]   <= wr_base_i[OUT_AW-1:PAGE_BITS];
        attr_q[g] <= wr_attr_i;
      end
    end
  end

  // unmatched indices fall through to zero
  always_comb begin
    lk_base_o = '0;
    lk_attr_o = '0;
    rd_base_o = '0;
    rd_attr_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (lk_idx_i == IW'(i)) begin
        lk_base_o = {hi_q[i], {PAGE_BITS{1'b0}}};
        lk_attr_o = attr_q[i];
      end
      if (rd_idx_i == IW'(i)) begin
        rd_base_o = {hi_q[i], {PAGE_BITS{1'b0}}};
        rd_attr_o = attr_q[i];
      end
    end
  end
endmodule

// File: rtl/pgx_map.sv
module pgx_map
  import pgx_pkg::*;
#(
  parameter int NUM_ENTRIES = 12,
  parameter int OUT_AW      = 64,
  parameter int PAGE_BITS   = 12,
  parameter int IW          = 4
) (
  input  logic [OUT_AW-1:0] addr_i,
  input  logic              wide_i,
  output logic [IW-1:0]     idx_o,
  input  logic [OUT_AW-1:0] base_i,
  input  attr_t             attr_i,
  output logic [OUT_AW-1:0] addr_o,
  output attr_t             attr_o,
  output logic              err_o
);
  logic [BUS_AW-1:0] slot;
  logic              in_range;

  assign slot     = addr_i[BUS_AW-1:0] >> PAGE_BITS;
  assign in_range = slot < BUS_AW'(NUM_ENTRIES);
  assign idx_o    = slot[IW-1:0];

  always_comb begin
    if (wide_i) begin
      addr_o = addr_i;
      attr_o = '0;
      err_o  = 1'b0;
    end else if (in_range) begin
      addr_o = {base_i[OUT_AW-1:PAGE_BITS], addr_i[PAGE_BITS-1:0]};
      attr_o = attr_i;
      err_o  = 1'b0;
    end else begin
      addr_o = '0;
      attr_o = '0;
      err_o  = 1'b1;
    end
  end
endmodule

// File: rtl/pgx_oreg.sv
module pgx_oreg
  import pgx_pkg::*;
#(
  parameter int OUT_AW = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [OUT_AW-1:0] addr_i,
  input  attr_t             attr_i,
  input  logic              err_i,
  output logic              vld_o,
  output logic [OUT_AW-1:0] addr_o,
  output attr_t             attr_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      err_o  <= 1'b0;
      addr_o <= '0;
      attr_o <= '0;
    end else begin
      vld_o  <= vld_i && !err_i;
      err_o  <= vld_i && err_i;
      addr_o <= vld_i ? addr_i : '0;
      attr_o <= vld_i ? attr_i : '0;
    end
  end
endmodule

// File: rtl/pg_xlate.sv
module pg_xlate
  import pgx_pkg::*;
#(
  parameter int NUM_ENTRIES = 12,
  parameter int OUT_AW      = 64,
  parameter int PAGE_BITS   = 12,
  localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IW-1:0]     cfg_idx_i,
  input  logic [OUT_AW-1:0] cfg_base_i,
  input  logic [1:0]        cfg_attr_i,
  output logic [OUT_AW-1:0] cfg_rd_base_o,
  output logic [1:0]        cfg_rd_attr_o,
  input  logic              req_valid_i,
  input  logic              req_wide_i,
  input  logic [OUT_AW-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [OUT_AW-1:0] rsp_addr_o,
  output logic [1:0]        rsp_attr_o,
  output logic              rsp_err_o
);
  logic [IW-1:0]     lk_idx;
  logic [OUT_AW-1:0] lk_base, nxt_addr;
  attr_t             lk_attr, nxt_attr, rd_attr, o_attr;
  logic              nxt_err;

  pgx_table #(
    .NUM_ENTRIES(NUM_ENTRIES), .OUT_AW(OUT_AW), .PAGE_BITS(PAGE_BITS), .IW(IW)
  ) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_base_i (cfg_base_i),
    .wr_attr_i (attr_t'(cfg_attr_i)),
    .lk_idx_i  (lk_idx),
    .lk_base_o (lk_base),
    .lk_attr_o (lk_attr),
    .rd_idx_i  (cfg_idx_i),
    .rd_base_o (cfg_rd_base_o),
    .rd_attr_o (rd_attr)
  );

  pgx_map #(
    .NUM_ENTRIES(NUM_ENTRIES), .OUT_AW(OUT_AW), .PAGE_BITS(PAGE_BITS), .IW(IW)
  ) u_map (
    .addr_i (req_addr_i),
    .wide_i (req_wide_i),
    .idx_o  (lk_idx),
    .base_i (lk_base),
    .attr_i (lk_attr),
    .addr_o (nxt_addr),
    .attr_o (nxt_attr),
    .err_o  (nxt_err)
  );

  pgx_oreg #(.OUT_AW(OUT_AW)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (req_valid_i),
    .addr_i (nxt_addr),
    .attr_i (nxt_attr),
    .err_i  (nxt_err),
    .vld_o  (rsp_valid_o),
    .addr_o (rsp_addr_o),
    .attr_o (o_attr),
    .err_o  (rsp_err_o)
  );

  assign cfg_rd_attr_o = rd_attr;
  assign rsp_attr_o    = o_attr;
endmodule

// File: rtl/pg_xlate_chk.sv
module pg_xlate_chk #(
  parameter int NUM_ENTRIES = 12,
  parameter int OUT_AW      = 64,
  parameter int PAGE_BITS   = 12,
  parameter int IW          = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [IW-1:0]     cfg_idx_i,
  input logic [OUT_AW-1:0] cfg_base_i,
  input logic [1:0]        cfg_attr_i,
  input logic [OUT_AW-1:0] cfg_rd_base_o,
  input logic [1:0]        cfg_rd_attr_o,
  input logic              req_valid_i,
  input logic              req_wide_i,
  input logic [OUT_AW-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic [OUT_AW-1:0] rsp_addr_o,
  input logic [1:0]        rsp_attr_o,
  input logic              rsp_err_o
);
  logic [31:0] slot_c;
  logic        hit_c;
  assign slot_c = req_addr_i[31:0] >> PAGE_BITS;
  assign hit_c  = slot_c < 32'(NUM_ENTRIES);

  a_r5_err_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !rsp_valid_o);

  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_wide_i && hit_c) |=>
      (rsp_valid_o && !rsp_err_o &&
       rsp_addr_o[PAGE_BITS-1:0] == $past(req_addr_i[PAGE_BITS-1:0])));

  a_r5_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_wide_i && !hit_c) |=>
      (rsp_err_o && rsp_addr_o == '0 && rsp_attr_o == 2'b00));

  a_r6_wide_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_wide_i) |=>
      (rsp_valid_o && !rsp_err_o && rsp_attr_o == 2'b00 &&
       rsp_addr_o == $past(req_addr_i)));

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_err_o && rsp_addr_o == '0));

  a_r2_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd_base_o[PAGE_BITS-1:0] == '0);

  a_r3_oob_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cfg_idx_i) >= 32'(NUM_ENTRIES)) |-> (cfg_rd_base_o == '0 && cfg_rd_attr_o == 2'b00));
endmodule

bind pg_xlate pg_xlate_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .OUT_AW(OUT_AW), .PAGE_BITS(PAGE_BITS), .IW(IW)
) u_chk (.*);

// File: tb/pg_xlate_test.sv
module pg_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM  = 12;
  localparam int PB   = 12;
  localparam int IW   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [63:0] cfg_base = '0;
  logic [1:0]  cfg_attr = '0;
  logic [63:0] rd_base;
  logic [1:0]  rd_attr;
  logic        req_v = 1'b0, req_w = 1'b0;
  logic [63:0] req_a = '0;
  logic        rsp_v, rsp_e;
  logic [63:0] rsp_a;
  logic [1:0]  rsp_t;

  int total = 0, bad = 0;
  logic [63:0] m_base [16];
  logic [1:0]  m_attr [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base), .cfg_attr_i(cfg_attr),
    .cfg_rd_base_o(rd_base), .cfg_rd_attr_o(rd_attr),
    .req_valid_i(req_v), .req_wide_i(req_w), .req_addr_i(req_a),
    .rsp_valid_o(rsp_v), .rsp_addr_o(rsp_a), .rsp_attr_o(rsp_t), .rsp_err_o(rsp_e)
  );

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, check read-back, predict, advance, compare
  task automatic step(input string tag, input bit v, input bit w, input logic [63:0] a,
                      input bit we, input int widx, input logic [63:0] wb, input logic [1:0] wa);
    logic        ev, ee;
    logic [63:0] ea;
    logic [1:0]  et;
    int          s;
    req_v = v; req_w = w; req_a = a;
    cfg_we = we; cfg_idx = IW'(widx); cfg_base = wb; cfg_attr = wa;
    #1;
    chk({tag, " read"}, {2'b00, rd_attr, rd_base}, {2'b00, m_attr[widx], m_base[widx]});
    ev = 0; ee = 0; ea = '0; et = '0;
    if (v) begin
      s = int'(a[31:0] >> PB);
      if (w) begin ev = 1; ea = a; end
      else if (s < NUM) begin ev = 1; ea = m_base[s] | {52'd0, a[11:0]}; et = m_attr[s]; end
      else ee = 1;
    end
    if (we && widx < NUM) begin
      m_base[widx] = wb & ~64'hFFF;
      m_attr[widx] = wa;
    end
    @(posedge clk); @(negedge clk);
    chk(tag, {rsp_v, rsp_e, rsp_t, rsp_a}, {ev, ee, et, ea});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_base[i] = '0; m_attr[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: outputs and table clear after reset
    chk("R1 rsp", {rsp_v, rsp_e, rsp_t, rsp_a}, 68'd0);
    for (int i = 0; i < 16; i++) step("R1", 0, 0, '0, 0, i, '0, '0);

    // R2: fill table, junk low bits must be dropped
    for (int i = 0; i < NUM; i++)
      step("R2", 0, 0, '0, 1, i, 64'hA500_0000_0000_0ABC ^ (64'(i) << 36) ^ 64'(i * 4097),
           2'(i % 4));
    for (int i = 0; i < NUM; i++) step("R2", 0, 0, '0, 0, i, '0, '0);

    // R3: out-of-range writes leave table unchanged
    step("R3", 0, 0, '0, 1, 13, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11);
    step("R3", 0, 0, '0, 1, 15, 64'h1234_5678_9ABC_D000, 2'b01);
    for (int i = 0; i < 16; i++) step("R3", 0, 0, '0, 0, i, '0, '0);

    // R4/R9: back-to-back translations with assorted offsets
    for (int i = 0; i < NUM; i++)
      step("R4 R9", 1, 0, {32'd0, 32'(i) << PB} | 64'((i * 331) & 32'hFFF), 0, 0, '0, '0);
    step("R9", 1, 0, 64'h0000_0000_0000_5FFF, 0, 0, '0, '0);
    step("R9", 1, 0, 64'h0000_0000_0000_0000, 0, 0, '0, '0);
    step("R9", 1, 0, 64'h0000_0000_0000_BFFF, 0, 0, '0, '0);

    // R5: slot numbers at and beyond the table size
    step("R5", 1, 0, 64'h0000_0000_0000_C000, 0, 0, '0, '0);
    step("R5", 1, 0, 64'h0000_0000_8000_0123, 0, 0, '0, '0);
    step("R5", 1, 0, 64'h0000_0000_0001_0000, 0, 0, '0, '0);
    step("R4", 1, 0, 64'h0000_0000_0000_B001, 0, 0, '0, '0);

    // R7: upper half ignored in translated mode
    step("R7", 1, 0, 64'hDEAD_BEEF_0000_3456, 0, 0, '0, '0);
    step("R7", 1, 0, 64'hFFFF_FFFF_0000_C000, 0, 0, '0, '0);

    // R6: wide bypass, including slot numbers out of range
    step("R6", 1, 1, 64'h0123_4567_89AB_CDEF, 0, 0, '0, '0);
    step("R6", 1, 1, 64'h0000_0000_0000_2345, 0, 0, '0, '0);
    step("R6", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, '0, '0);

    // R8: write and lookup of the same slot collide
    step("R8", 1, 0, 64'h0000_0000_0000_3777, 1, 3, 64'h7700_0000_CAFE_F123, 2'b10);
    step("R8", 1, 0, 64'h0000_0000_0000_3777, 0, 3, '0, '0);
    step("R8", 1, 0, 64'h0000_0000_0000_7001, 1, 7, 64'h0000_0001_0000_0FFF, 2'b01);
    step("R8", 1, 0, 64'h0000_0000_0000_7001, 1, 7, 64'h0000_0002_0000_0000, 2'b11);
    step("R8", 1, 0, 64'h0000_0000_0000_7001, 0, 7, '0, '0);

    // R10: idle cycles after activity
    step("R10", 0, 0, 64'h0000_0000_0000_1234, 0, 0, '0, '0);
    step("R10", 0, 1, 64'h0000_0000_0000_C000, 0, 0, '0, '0);
    step("R4", 1, 0, 64'h0000_0000_0000_0FFF, 0, 0, '0, '0);
    step("R10", 0, 0, '0, 0, 0, '0, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule